// File: doc/BRIEF.md
# Parallel Bus Write Sequencer for a Display Controller

This block turns single-byte write requests into complete write cycles on an 8-bit parallel bus of the kind used with write strobe, read strobe and chip select lines, as found on small display controllers. A requester offers a byte together with a flag that says whether the byte is pixel data or a command. The block lowers chip select, sets up the data/command line and the data bus, pulses the write strobe, then holds everything for the required hold time before releasing chip select.

Every interval is written as a nanosecond minimum in a parameter. The block converts each one to whole system clock cycles by rounding up, and never uses fewer than one cycle. With the default 8 ns clock, chip select leads the strobe by 2 cycles, the strobe is low for 8 cycles, and chip select is held for 3 cycles after the strobe rises. The request port stays not-ready until a new write cycle can start without breaking the minimum strobe-to-strobe period, which is 38 cycles at the defaults. Back-to-back requests therefore run at that period exactly. Reads are not supported, so the read strobe stays high.

Top module: `par_wr_master`

## Requirements
- R1: While reset (synchronous, active low) is asserted, chip select, write strobe and read strobe are all high, the data/command line and the data bus are zero, and ready is high after reset releases.
- R2: The data/command line carries the accepted flag: 1 for display data, 0 for a command, and this value is present when the write strobe rises.
- R3: The data bus carries the accepted byte, and the bus and the data/command line do not change while chip select is low.
- R4: Chip select falls exactly SU cycles before the write strobe falls. SU is the larger of the data/command setup minimum (10 ns) and the chip select setup minimum (0 ns), rounded up to whole clock cycles with a floor of one. This is 2 at the defaults.
- R5: The write strobe stays low exactly LO cycles, and only while chip select is low. LO is the larger of the strobe-low minimum (60 ns) and the data-setup-to-rise minimum (40 ns), each rounded up to cycles. This is 8 at the defaults.
- R6: Chip select rises exactly HO cycles after the write strobe rises. HO is the largest of the chip select hold (20 ns), data hold (7 ns) and data/command hold (0 ns) minimums in cycles. This is 3 at the defaults.
- R7: Consecutive write strobe falling edges are at least CYC cycles apart, where CYC is the larger of the 300 ns cycle time in cycles and LO plus the strobe-high minimum (60 ns) in cycles. This is 38 at the defaults. The strobe is also high for at least the strobe-high minimum between writes. For back-to-back requests the spacing is exactly CYC.
- R8: A request is taken only on a clock edge where valid and ready are both high. Ready is low from acceptance until chip select is released and the next strobe would meet R7.
- R9: The read strobe is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_is_data | input | 1 | 1 = display data, 0 = command |
| req_byte | input | DW (8) | Byte to write |
| req_ready | output | 1 | Block can take a request this cycle |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, held high |
| bus_dc | output | 1 | Data/command select |
| bus_db | output | DW (8) | Parallel data bus |

## Verification
All bus pins are driven from registers. The acceptance edge therefore shows up one cycle later as chip select low, SU cycles after that as the strobe fall, LO cycles later as the rise, and HO cycles later as the chip select release. The monitor samples on the falling clock edge and timestamps each pin transition with a negedge count. Each measured distance is compared with SU, LO, HO and CYC, which the bench works out itself from the nanosecond minimums. Expected bytes and flags are queued by the driver and popped at each strobe rise. A burst of three back-to-back requests checks that the strobe period is exactly CYC.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HOLD  = 2'd3
  } phase_t;

  // Whole clock cycles covering a nanosecond minimum, never less than one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwm_span_timer.sv
module pwm_span_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] count;

  always_ff @(posedge clk) begin
    if (!rst_n)          count <= '0;
    else if (load)       count <= len - 1'b1;
    else if (count != 0) count <= count - 1'b1;
  end

  assign expired = (count == '0);
endmodule

// File: rtl/pwm_age_ctr.sv
module pwm_age_ctr #(
  parameter int unsigned MAXV = 38,
  parameter int unsigned W    = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);
  always_ff @(posedge clk) begin
    if (!rst_n)                age <= W'(MAXV);
    else if (restart)          age <= W'(1);
    else if (age < W'(MAXV))   age <= age + 1'b1;
  end
endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
  import pwm_pkg::*;
#(
  parameter int unsigned SU = 2,
  parameter int unsigned LO = 8,
  parameter int unsigned HO = 3,
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          tmr_expired,
  output phase_t        phase,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_len,
  output logic          strobe_fall,
  output logic          strobe_rise
);
  phase_t nxt;

  always_comb begin
    nxt      = phase;
    tmr_load = 1'b0;
    tmr_len  = TW'(SU);
    case (phase)
      PH_IDLE:  if (accept) begin
                  nxt = PH_SETUP; tmr_load = 1'b1; tmr_len = TW'(SU);
                end
      PH_SETUP: if (tmr_expired) begin
                  nxt = PH_LOW; tmr_load = 1'b1; tmr_len = TW'(LO);
                end
      PH_LOW:   if (tmr_expired) begin
                  nxt = PH_HOLD; tmr_load = 1'b1; tmr_len = TW'(HO);
                end
      PH_HOLD:  if (tmr_expired) nxt = PH_IDLE;
      default:  nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  assign strobe_fall = (phase == PH_SETUP) && tmr_expired;
  assign strobe_rise = (phase == PH_LOW)   && tmr_expired;
endmodule

// File: rtl/par_wr_master.sv
module par_wr_master
  import pwm_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 8,
  parameter int unsigned DW              = 8,
  parameter int unsigned T_DC_SETUP_NS   = 10,
  parameter int unsigned T_CS_SETUP_NS   = 0,
  parameter int unsigned T_WR_LOW_NS     = 60,
  parameter int unsigned T_WR_HIGH_NS    = 60,
  parameter int unsigned T_WR_CYCLE_NS   = 300,
  parameter int unsigned T_DATA_SETUP_NS = 40,
  parameter int unsigned T_DATA_HOLD_NS  = 7,
  parameter int unsigned T_DC_HOLD_NS    = 0,
  parameter int unsigned T_CS_HOLD_NS    = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_data,
  input  logic [DW-1:0] req_byte,
  output logic          req_ready,
  output logic          bus_cs_n,
  output logic          bus_wr_n,
  output logic          bus_rd_n,
  output logic          bus_dc,
  output logic [DW-1:0] bus_db
);
  localparam int unsigned SU_CYC  = ns_to_cyc(max2(T_DC_SETUP_NS, T_CS_SETUP_NS), CLK_PERIOD_NS);
  localparam int unsigned LO_CYC  = max2(ns_to_cyc(T_WR_LOW_NS, CLK_PERIOD_NS),
                                         ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int unsigned HO_CYC  = ns_to_cyc(max2(T_CS_HOLD_NS, max2(T_DATA_HOLD_NS, T_DC_HOLD_NS)),
                                              CLK_PERIOD_NS);
  localparam int unsigned HI_CYC  = ns_to_cyc(T_WR_HIGH_NS, CLK_PERIOD_NS);
  localparam int unsigned CYC_CYC = max2(ns_to_cyc(T_WR_CYCLE_NS, CLK_PERIOD_NS), LO_CYC + HI_CYC);
  localparam int unsigned TW      = $clog2(max2(SU_CYC, max2(LO_CYC, HO_CYC)) + 1);
  localparam int unsigned AGE_MAX = max2(CYC_CYC, HI_CYC);
  localparam int unsigned AW      = $clog2(AGE_MAX + 1);
  // Age a past edge must reach at acceptance so the new fall lands SU cycles later in time.
  localparam int unsigned FALL_NEED = (CYC_CYC > SU_CYC) ? CYC_CYC - SU_CYC : 0;
  localparam int unsigned RISE_NEED = (HI_CYC  > SU_CYC) ? HI_CYC  - SU_CYC : 0;

  phase_t          phase;
  logic            tmr_load, tmr_done;
  logic [TW-1:0]   tmr_len;
  logic            strobe_fall, strobe_rise;
  logic            xfer_accept;
  logic            gap_ok;
  logic [1:0]      age_restart;
  logic [AW-1:0]   age [2];
  logic [DW-1:0]   db_q;
  logic            dc_q;

  assign xfer_accept = req_valid && req_ready;

  pwm_seq #(.SU(SU_CYC), .LO(LO_CYC), .HO(HO_CYC), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(xfer_accept), .tmr_expired(tmr_done),
    .phase(phase), .tmr_load(tmr_load), .tmr_len(tmr_len),
    .strobe_fall(strobe_fall), .strobe_rise(strobe_rise)
  );

  pwm_span_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .expired(tmr_done)
  );

  // index 0: age since last strobe fall, index 1: age since last strobe rise
  assign age_restart = {strobe_rise, strobe_fall};
  for (genvar g = 0; g < 2; g++) begin : g_age
    pwm_age_ctr #(.MAXV(AGE_MAX), .W(AW)) u_age (
      .clk(clk), .rst_n(rst_n), .restart(age_restart[g]), .age(age[g])
    );
  end

  assign gap_ok    = (age[0] >= AW'(FALL_NEED)) && (age[1] >= AW'(RISE_NEED));
  assign req_ready = (phase == PH_IDLE) && gap_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q <= '0;
      dc_q <= 1'b0;
    end else if (xfer_accept) begin
      db_q <= req_byte;
      dc_q <= req_is_data;
    end
  end

  assign bus_cs_n = (phase == PH_IDLE);
  assign bus_wr_n = (phase != PH_LOW);
  assign bus_rd_n = 1'b1;
  assign bus_dc   = dc_q;
  assign bus_db   = db_q;
endmodule

// File: rtl/pwm_chk.sv
module pwm_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned LO_N  = 8,
  parameter int unsigned CYC_N = 38
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          xfer_accept,
  input logic          bus_cs_n,
  input logic          bus_wr_n,
  input logic          bus_rd_n,
  input logic          bus_dc,
  input logic [DW-1:0] bus_db
);
  logic [15:0] low_run;
  logic [15:0] fall_gap;
  logic        wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_run  <= '0;
      fall_gap <= 16'(CYC_N);
      wr_q     <= 1'b1;
    end else begin
      wr_q    <= bus_wr_n;
      low_run <= bus_wr_n ? 16'd0 : low_run + 16'd1;
      if (!bus_wr_n && wr_q)          fall_gap <= 16'd1;
      else if (fall_gap < 16'(CYC_N)) fall_gap <= fall_gap + 16'd1;
    end
  end

  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_rd_n);
  // R5
  wr_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_wr_n |-> !bus_cs_n);
  // R5
  wr_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> low_run == 16'(LO_N));
  // R7
  fall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> fall_gap >= 16'(CYC_N));
  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_db) && $stable(bus_dc)));
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> bus_cs_n);
  // R8
  accept_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_accept |=> (!bus_cs_n && !req_ready));
endmodule

bind par_wr_master pwm_chk #(.DW(DW), .LO_N(LO_CYC), .CYC_N(CYC_CYC)) u_chk (.*);

// File: tb/sim_par_wr_master.sv
module sim_par_wr_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_is_data = 1'b0;
  logic [7:0] req_byte = '0;
  logic       req_ready, bus_cs_n, bus_wr_n, bus_rd_n, bus_dc;
  logic [7:0] bus_db;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  par_wr_master u0 (.*);

  function automatic int cyc_of(input int ns);
    int c = 0;
    while (c * 8 < ns) c++;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int bigger(input int a, input int b);
    return (a >= b) ? a : b;
  endfunction

  int su_e, lo_e, ho_e, hi_e, cyc_e;
  initial begin
    su_e  = bigger(cyc_of(10), cyc_of(0));
    lo_e  = bigger(cyc_of(60), cyc_of(40));
    ho_e  = bigger(cyc_of(20), bigger(cyc_of(7), cyc_of(0)));
    hi_e  = cyc_of(60);
    cyc_e = bigger(cyc_of(300), lo_e + hi_e);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic [8:0] exp_q[$];
  int falls[$];

  task automatic send(input logic is_data, input logic [7:0] b);
    @(negedge clk);
    req_valid = 1'b1; req_is_data = is_data; req_byte = b;
    exp_q.push_back({is_data, b});
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  // monitor
  int ncyc = 0, t_cs = 0, t_wf = -1, t_wr = -1;
  int rd_bad = 0, hold_bad = 0;
  logic p_cs = 1, p_wr = 1, p_dc = 0;
  logic [7:0] p_db = 0;
  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      if (bus_rd_n !== 1'b1) rd_bad++;
      if (!bus_cs_n && !p_cs && (bus_db !== p_db || bus_dc !== p_dc)) hold_bad++;
      if (p_cs && !bus_cs_n) t_cs = ncyc;
      if (p_wr && !bus_wr_n) begin
        chk("R4 cs-to-strobe cycles", ncyc - t_cs, su_e);
        if (t_wf >= 0) chk("R7 fall spacing at least CYC", int'(ncyc - t_wf >= cyc_e), 1);
        if (t_wr >= 0) chk("R7 strobe high time", int'(ncyc - t_wr >= hi_e), 1);
        t_wf = ncyc;
        falls.push_back(ncyc);
      end
      if (!p_wr && bus_wr_n) begin
        logic [8:0] e;
        chk("R5 strobe low cycles", ncyc - t_wf, lo_e);
        t_wr = ncyc;
        if (exp_q.size() == 0) chk("R2 unexpected write", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk("R2 dc line", int'(bus_dc), int'(e[8]));
          chk("R3 data byte", int'(bus_db), int'(e[7:0]));
        end
      end
      if (!p_cs && bus_cs_n) chk("R6 strobe-rise-to-cs-release", ncyc - t_wr, ho_e);
    end
    p_cs = bus_cs_n; p_wr = bus_wr_n; p_dc = bus_dc; p_db = bus_db;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", int'(bus_cs_n), 1);
    chk("R1 wr_n", int'(bus_wr_n), 1);
    chk("R1 rd_n", int'(bus_rd_n), 1);
    chk("R1 db", int'(bus_db), 0);
    chk("R1 dc", int'(bus_dc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(req_ready), 1);

    send(1'b0, 8'h00);
    @(negedge clk);
    chk("R8 ready low after accept", int'(req_ready), 0);
    repeat (60) @(negedge clk);
    send(1'b1, 8'hFF);
    repeat (60) @(negedge clk);
    send(1'b1, 8'hA5);
    repeat (45) @(negedge clk);
    send(1'b0, 8'h5A);
    repeat (60) @(negedge clk);

    // back-to-back burst: R7 exact spacing
    falls.delete();
    fork
      begin send(1'b1, 8'h01); send(1'b0, 8'h80); send(1'b1, 8'h3C); end
    join
    repeat (60) @(negedge clk);
    chk("R7 burst strobe count", falls.size(), 3);
    if (falls.size() == 3) begin
      chk("R7 back-to-back spacing 1", falls[1] - falls[0], cyc_e);
      chk("R7 back-to-back spacing 2", falls[2] - falls[1], cyc_e);
    end
    chk("R2 all writes seen", exp_q.size(), 0);
    chk("R9 read strobe never low", rd_bad, 0);
    chk("R3 bus stable while selected", hold_bad, 0);
    chk("R8 idle ready", int'(req_ready), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule